// File: doc/BRIEF.md
# Debug Halt Entry Controller

This block decides when a processor core stops in a halted debug state and when it runs again. It watches single-cycle event strobes from the core, an asynchronous external break pin and writes to its own control register. When any enabled halt cause fires while the core is running, the block asserts a pipeline hold, raises a debug-active flag and records a three-bit cause code. A debugger leaves the halted state by writing a resume bit.

Every bus master reaches the block through one 2 MB address window, which is split into four quadrants by the two top offset bits: 0 holds control registers, 1 the core-register/cache region, 2 the trace region, 3 is unmapped. Control registers are open at all times. The core region is open only while halted. The trace region is open only while tracing is disabled or the trace unit reports completion. For a permitted region access the block raises a same-cycle enable strobe toward the region owner. A refused access gets an error response and no enable strobe. Every access that hits the window gets a response one cycle later.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After reset, dbg_active and core_hold are 0, and the control, cause and trap-mask registers all read 0.
- R2: An ev_swbrk strobe while running sets dbg_active and core_hold at the next clock edge, with cause code 3.
- R3: A trap strobe whose type equals HW_TRAP_TT (default 0x0B) halts at the next edge with cause code 2, whatever the trap-filter bits say.
- R4: An ev_err_trap strobe halts at the next edge with cause code 1.
- R5: The break pin passes through a two-flop synchronizer and then an edge detector. A rising edge set up before edge 1 halts at clock edge 3 with cause code 6. A pin that stays high after resume does not halt again.
- R6: Writing 1 to control bit 4 (break-now) halts at that write's edge with cause code 7. While halted, further events are ignored and the cause register keeps its value.
- R7: With control bit 1 set, any trap halts with cause 4. With control bit 2 set, a trap of type t halts with cause 4 only if t < 32 and trap-mask bit t is 1. With both bits clear, traps other than HW_TRAP_TT have no effect.
- R8: ev_step_done halts with cause 5 only when control bit 3 (step enable) is 1. Otherwise it has no effect.
- R9: When several causes fire in one cycle, the lowest cause code is recorded (1 error trap, 2 hardware trap, 3 software breakpoint, 4 filtered trap, 5 step, 6 external pin, 7 break-now).
- R10: Writing 1 to control bit 5 while halted clears dbg_active and core_hold at that edge. core_hold always equals dbg_active.
- R11: A core-region access (offset bits [20:19] = 1) raises core_rgn_en and gets a clean response only while halted. While running it gets bus_err with no enable.
- R12: A trace-region access (offset bits [20:19] = 2) raises trace_rgn_en and gets a clean response when control bit 0 (trace enable) is 0 or trc_done is 1. Otherwise it gets bus_err with no enable.
- R13: Accesses outside the window (address bits [31:21] differ from WIN_BASE) get no bus_ack. Accesses to offset quadrant 3 get bus_ack with bus_err. bus_ack and bus_err follow the access by one cycle.
- R14: Control register offsets are 0x0 (control), 0x4 (cause, read-only) and 0x8 (trap mask). A write to 0x0 loads bits [3:0]. A control read returns bits [3:0], with dbg_active in bit 6 and bits 4 and 5 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_swbrk | input | 1 | Software breakpoint instruction executed |
| ev_trap_vld | input | 1 | A trap is being taken |
| ev_trap_type | input | TT_W | Type number of the trap |
| ev_err_trap | input | 1 | Trap that would otherwise enter error mode |
| ev_step_done | input | 1 | Single-stepped instruction retired |
| brk_pin | input | 1 | Asynchronous external break request |
| trc_done | input | 1 | Trace unit finished capturing |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | Access is a write |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Response for an access that hit the window |
| bus_err | output | 1 | Error response (refused or unmapped) |
| bus_rdata | output | 32 | Control register read data |
| core_rgn_en | output | 1 | Permitted core-region access strobe |
| trace_rgn_en | output | 1 | Permitted trace-region access strobe |
| core_hold | output | 1 | Pipeline hold toward the core |
| dbg_active | output | 1 | Core is in halted debug mode |

## Verification
The hardest situation to reach is the external break. Its effect appears three edges after the pin moves. Halting again requires a fresh low-to-high transition, which is hidden behind the synchronizer. The bench checks the flag one cycle before and at the expected edge. It then resumes while the pin stays high and watches for several cycles that no second halt appears. Causes that fire in the same cycle are produced by raising several strobes within one cycle. Filter rejection is shown with a trap type whose low five bits select an enabled mask bit but whose value is above 31.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

  typedef enum logic [2:0] {
    CS_NONE      = 3'd0,
    CS_ERR_TRAP  = 3'd1,
    CS_HW_TRAP   = 3'd2,
    CS_SW_BRK    = 3'd3,
    CS_TRAP_FILT = 3'd4,
    CS_STEP      = 3'd5,
    CS_EXT_BRK   = 3'd6,
    CS_BRK_NOW   = 3'd7
  } halt_cause_e;

  localparam int NUM_CAUSES = 7;

  // window quadrants selected by the top two offset bits
  localparam logic [1:0] RG_CTRL  = 2'd0;
  localparam logic [1:0] RG_CORE  = 2'd1;
  localparam logic [1:0] RG_TRACE = 2'd2;

  // word offsets inside the control quadrant
  localparam logic [1:0] OFS_CTRL  = 2'd0;
  localparam logic [1:0] OFS_CAUSE = 2'd1;
  localparam logic [1:0] OFS_MASK  = 2'd2;

  // control word bit positions
  localparam int CB_TRC_EN   = 0;
  localparam int CB_ANY_TRAP = 1;
  localparam int CB_SEL_TRAP = 2;
  localparam int CB_STEP_EN  = 3;
  localparam int CB_BRK_NOW  = 4;
  localparam int CB_RESUME   = 5;
  localparam int CB_ACTIVE   = 6;
  localparam int CFG_W       = 4;

endpackage

// File: rtl/dbg_brk_sync.sv
module dbg_brk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/dbg_cause_merge.sv
module dbg_cause_merge
  import dbg_halt_pkg::*;
#(
  parameter int N = NUM_CAUSES
) (
  input  logic [N:1]  req,
  output logic        any,
  output halt_cause_e cause
);
  logic [2:0] code;

  always_comb begin
    code = 3'd0;
    // walk downward so the lowest active index is kept
    for (int i = N; i >= 1; i--) begin
      if (req[i]) code = 3'(i);
    end
  end

  assign any   = |req;
  assign cause = halt_cause_e'(code);
endmodule

// File: rtl/dbg_bus_regs.sv
module dbg_bus_regs
  import dbg_halt_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h9000_0000,
  parameter int              WIN_BITS = 21,
  parameter int              MASK_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              dbg_active,
  input  logic [2:0]        halt_cause,
  input  logic              trc_done,
  output logic              bus_ack,
  output logic              bus_err,
  output logic [31:0]       bus_rdata,
  output logic              core_rgn_en,
  output logic              trace_rgn_en,
  output logic              brk_now_pulse,
  output logic              resume_pulse,
  output logic [CFG_W-1:0]  cfg,
  output logic [MASK_W-1:0] trap_mask
);
  localparam int RG_HI = WIN_BITS - 1;
  localparam int RG_LO = WIN_BITS - 2;

  logic              win_hit, ctrl_hit, allowed, trace_open;
  logic [1:0]        region, ofs;
  logic [CFG_W-1:0]  cfg_q, cfg_d;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic              cfg_en, mask_en;
  logic              ack_d, err_d, ack_q, err_q;
  logic [31:0]       rdata_d, rdata_q;

  assign win_hit    = bus_sel && (bus_addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);
  assign region     = bus_addr[RG_HI:RG_LO];
  assign ofs        = bus_addr[3:2];
  assign ctrl_hit   = win_hit && (region == RG_CTRL);
  assign trace_open = !cfg_q[CB_TRC_EN] || trc_done;

  always_comb begin
    case (region)
      RG_CTRL:  allowed = 1'b1;
      RG_CORE:  allowed = dbg_active;
      RG_TRACE: allowed = trace_open;
      default:  allowed = 1'b0;
    endcase
  end

  assign core_rgn_en  = win_hit && (region == RG_CORE)  && dbg_active;
  assign trace_rgn_en = win_hit && (region == RG_TRACE) && trace_open;

  // register writes and single-cycle command bits
  assign cfg_en        = ctrl_hit && bus_we && (ofs == OFS_CTRL);
  assign mask_en       = ctrl_hit && bus_we && (ofs == OFS_MASK);
  assign brk_now_pulse = cfg_en && bus_wdata[CB_BRK_NOW];
  assign resume_pulse  = cfg_en && bus_wdata[CB_RESUME];
  assign cfg_d         = cfg_en  ? bus_wdata[CFG_W-1:0]  : cfg_q;
  assign mask_d        = mask_en ? bus_wdata[MASK_W-1:0] : mask_q;

  always_comb begin
    rdata_d = '0;
    if (ctrl_hit && !bus_we) begin
      case (ofs)
        OFS_CTRL: begin
          rdata_d[CFG_W-1:0] = cfg_q;
          rdata_d[CB_ACTIVE] = dbg_active;
        end
        OFS_CAUSE: rdata_d[2:0]        = halt_cause;
        OFS_MASK:  rdata_d[MASK_W-1:0] = mask_q;
        default:   rdata_d = '0;
      endcase
    end
  end

  assign ack_d = win_hit;
  assign err_d = win_hit && !allowed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      mask_q  <= '0;
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      cfg_q  <= cfg_d;
      mask_q <= mask_d;
      ack_q  <= ack_d;
      err_q  <= err_d;
      if (win_hit) rdata_q <= rdata_d;
    end
  end

  assign bus_ack   = ack_q;
  assign bus_err   = err_q;
  assign bus_rdata = rdata_q;
  assign cfg       = cfg_q;
  assign trap_mask = mask_q;

  logic unused_bits;
  assign unused_bits = ^{bus_addr[RG_LO-1:4], bus_addr[1:0], bus_wdata};
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int                ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE    = 32'h9000_0000,
  parameter int                WIN_BITS    = 21,
  parameter int                TT_W        = 8,
  parameter logic [TT_W-1:0]   HW_TRAP_TT  = 8'h0B,
  parameter int                SYNC_STAGES = 2,
  parameter int                MASK_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_swbrk,
  input  logic              ev_trap_vld,
  input  logic [TT_W-1:0]   ev_trap_type,
  input  logic              ev_err_trap,
  input  logic              ev_step_done,
  input  logic              brk_pin,
  input  logic              trc_done,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic              bus_ack,
  output logic              bus_err,
  output logic [31:0]       bus_rdata,
  output logic              core_rgn_en,
  output logic              trace_rgn_en,
  output logic              core_hold,
  output logic              dbg_active
);
  localparam int IDX_W = $clog2(MASK_W);

  logic              ext_rise, brk_now_pulse, resume_pulse;
  logic [CFG_W-1:0]  cfg;
  logic [MASK_W-1:0] trap_mask;
  logic [NUM_CAUSES:1] req;
  logic              req_any;
  halt_cause_e       req_cause;
  logic              tt_in_range, tt_is_hw, tt_filtered;
  logic              active_q, active_d;
  logic [2:0]        cause_q, cause_d;
  logic              cause_en;

  dbg_brk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (brk_pin),
    .rise (ext_rise)
  );

  dbg_bus_regs #(
    .ADDR_W  (ADDR_W),
    .WIN_BASE(WIN_BASE),
    .WIN_BITS(WIN_BITS),
    .MASK_W  (MASK_W)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_we       (bus_we),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .dbg_active   (active_q),
    .halt_cause   (cause_q),
    .trc_done     (trc_done),
    .bus_ack      (bus_ack),
    .bus_err      (bus_err),
    .bus_rdata    (bus_rdata),
    .core_rgn_en  (core_rgn_en),
    .trace_rgn_en (trace_rgn_en),
    .brk_now_pulse(brk_now_pulse),
    .resume_pulse (resume_pulse),
    .cfg          (cfg),
    .trap_mask    (trap_mask)
  );

  // trap classification
  assign tt_in_range = (ev_trap_type >> IDX_W) == '0;
  assign tt_is_hw    = ev_trap_vld && (ev_trap_type == HW_TRAP_TT);
  assign tt_filtered = ev_trap_vld &&
                       (cfg[CB_ANY_TRAP] ||
                        (cfg[CB_SEL_TRAP] && tt_in_range && trap_mask[ev_trap_type[IDX_W-1:0]]));

  // request vector indexed by cause code
  assign req[CS_ERR_TRAP]  = ev_err_trap;
  assign req[CS_HW_TRAP]   = tt_is_hw;
  assign req[CS_SW_BRK]    = ev_swbrk;
  assign req[CS_TRAP_FILT] = tt_filtered;
  assign req[CS_STEP]      = ev_step_done && cfg[CB_STEP_EN];
  assign req[CS_EXT_BRK]   = ext_rise;
  assign req[CS_BRK_NOW]   = brk_now_pulse;

  dbg_cause_merge #(.N(NUM_CAUSES)) u_merge (
    .req  (req),
    .any  (req_any),
    .cause(req_cause)
  );

  always_comb begin
    active_d = active_q;
    cause_en = 1'b0;
    if (active_q) begin
      if (resume_pulse) active_d = 1'b0;
    end else if (req_any) begin
      active_d = 1'b1;
      cause_en = 1'b1;
    end
    cause_d = cause_en ? req_cause : cause_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cause_q  <= 3'd0;
    end else begin
      active_q <= active_d;
      cause_q  <= cause_d;
    end
  end

  assign core_hold  = active_q;
  assign dbg_active = active_q;
endmodule

// File: rtl/dbg_halt_ctrl_chk.sv
module dbg_halt_ctrl_chk #(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h9000_0000,
  parameter int                WIN_BITS   = 21,
  parameter int                TT_W       = 8,
  parameter logic [TT_W-1:0]   HW_TRAP_TT = 8'h0B
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_swbrk,
  input logic              ev_trap_vld,
  input logic [TT_W-1:0]   ev_trap_type,
  input logic              ev_err_trap,
  input logic              bus_sel,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ack,
  input logic              bus_err,
  input logic              core_rgn_en,
  input logic              trace_rgn_en,
  input logic              trc_en,
  input logic              trc_done,
  input logic              core_hold,
  input logic              dbg_active,
  input logic [2:0]        cause
);
  logic in_win;
  assign in_win = bus_addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS];

  p_core_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    core_rgn_en |-> dbg_active);

  p_trace_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    trace_rgn_en |-> (!trc_en || trc_done));

  p_swbrk_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_active && ev_swbrk) |=> (dbg_active && core_hold));

  p_hw_trap_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_active && ev_trap_vld && ev_trap_type == HW_TRAP_TT && !ev_err_trap)
      |=> (dbg_active && cause == 3'd2));

  p_err_trap_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_active && ev_err_trap) |=> (dbg_active && cause == 3'd1));

  p_cause_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_active && $past(dbg_active)) |-> $stable(cause));

  p_outside_silent_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !in_win) |=> !bus_ack);

  p_err_with_ack_r13: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> bus_ack);
endmodule

bind dbg_halt_ctrl dbg_halt_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .WIN_BASE  (WIN_BASE),
  .WIN_BITS  (WIN_BITS),
  .TT_W      (TT_W),
  .HW_TRAP_TT(HW_TRAP_TT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_swbrk    (ev_swbrk),
  .ev_trap_vld (ev_trap_vld),
  .ev_trap_type(ev_trap_type),
  .ev_err_trap (ev_err_trap),
  .bus_sel     (bus_sel),
  .bus_addr    (bus_addr),
  .bus_ack     (bus_ack),
  .bus_err     (bus_err),
  .core_rgn_en (core_rgn_en),
  .trace_rgn_en(trace_rgn_en),
  .trc_en      (cfg[0]),
  .trc_done    (trc_done),
  .core_hold   (core_hold),
  .dbg_active  (dbg_active),
  .cause       (cause_q)
);

// File: tb/dbg_halt_ctrl_tb.sv
`timescale 1ns/1ps
module dbg_halt_ctrl_tb;
  localparam logic [31:0] BASE   = 32'h9000_0000;
  localparam logic [31:0] A_CTRL = BASE + 32'h0;
  localparam logic [31:0] A_CAUS = BASE + 32'h4;
  localparam logic [31:0] A_MASK = BASE + 32'h8;
  localparam logic [31:0] A_CORE = BASE + 32'h0008_0010;
  localparam logic [31:0] A_TRC  = BASE + 32'h0010_0020;
  localparam logic [31:0] A_NONE = BASE + 32'h0018_0000;
  localparam logic [31:0] A_OUT  = 32'h1000_0000;

  logic clk, rst_n;
  logic ev_swbrk, ev_trap_vld, ev_err_trap, ev_step_done, brk_pin, trc_done;
  logic [7:0] ev_trap_type;
  logic bus_sel, bus_we;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic bus_ack, bus_err, core_rgn_en, trace_rgn_en, core_hold, dbg_active;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] cur_ctrl = 0;
  logic r_ack, r_err, r_core, r_trc;
  logic [31:0] r_data;

  dbg_halt_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ev_swbrk(ev_swbrk), .ev_trap_vld(ev_trap_vld),
    .ev_trap_type(ev_trap_type), .ev_err_trap(ev_err_trap), .ev_step_done(ev_step_done),
    .brk_pin(brk_pin), .trc_done(trc_done), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_err(bus_err),
    .bus_rdata(bus_rdata), .core_rgn_en(core_rgn_en), .trace_rgn_en(trace_rgn_en),
    .core_hold(core_hold), .dbg_active(dbg_active)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_acc(input logic we, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    #1; r_core = core_rgn_en; r_trc = trace_rgn_en;
    @(negedge clk);
    r_ack = bus_ack; r_err = bus_err; r_data = bus_rdata;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic set_ctrl(input logic [31:0] v);
    cur_ctrl = v;
    bus_acc(1, A_CTRL, v);
  endtask

  task automatic rd_cause(input string req, input logic [31:0] exp);
    bus_acc(0, A_CAUS, 0);
    check(req, r_data, exp);
  endtask

  task automatic resume(input string req);
    bus_acc(1, A_CTRL, cur_ctrl | 32'h20);
    check(req, {30'd0, core_hold, dbg_active}, 32'h0);
  endtask

  task automatic fire(input logic sw, input logic tv, input logic [7:0] tt,
                      input logic er, input logic st);
    @(negedge clk);
    ev_swbrk = sw; ev_trap_vld = tv; ev_trap_type = tt; ev_err_trap = er; ev_step_done = st;
    @(negedge clk);
    ev_swbrk = 0; ev_trap_vld = 0; ev_trap_type = 0; ev_err_trap = 0; ev_step_done = 0;
  endtask

  task automatic t_reset;
    check("R1 active", {31'd0, dbg_active}, 0);
    check("R1 hold", {31'd0, core_hold}, 0);
    bus_acc(0, A_CTRL, 0); check("R1 ctrl", r_data, 0);
    rd_cause("R1 cause", 0);
    bus_acc(0, A_MASK, 0); check("R1 mask", r_data, 0);
  endtask

  task automatic t_swbrk;
    fire(1, 0, 0, 0, 0);
    check("R2 halt", {30'd0, core_hold, dbg_active}, 32'h3);
    rd_cause("R2 cause", 3);
    resume("R10 resume");
  endtask

  task automatic t_hwtrap;
    fire(0, 1, 8'h0B, 0, 0);
    check("R3 halt", {31'd0, dbg_active}, 1);
    rd_cause("R3 cause", 2);
    resume("R10 resume");
    fire(0, 1, 8'h05, 0, 0);
    check("R7 unfiltered trap ignored", {31'd0, dbg_active}, 0);
  endtask

  task automatic t_errtrap;
    fire(0, 0, 0, 1, 0);
    check("R4 halt", {31'd0, dbg_active}, 1);
    rd_cause("R4 cause", 1);
    resume("R10 resume");
  endtask

  task automatic t_ext;
    @(negedge clk); brk_pin = 1;
    @(negedge clk);
    @(negedge clk); check("R5 not yet", {31'd0, dbg_active}, 0);
    @(negedge clk); check("R5 halt at third edge", {31'd0, dbg_active}, 1);
    rd_cause("R5 cause", 6);
    resume("R10 resume");
    repeat (6) @(negedge clk);
    check("R5 level no rehalt", {31'd0, dbg_active}, 0);
    brk_pin = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_brknow;
    bus_acc(1, A_CTRL, 32'h10);
    check("R6 halt", {31'd0, dbg_active}, 1);
    fire(1, 0, 0, 1, 0);
    rd_cause("R6 cause kept", 7);
    bus_acc(0, A_CTRL, 0);
    check("R14 ctrl read active", r_data, 32'h40);
    resume("R10 resume");
  endtask

  task automatic t_filter;
    set_ctrl(32'h2);
    fire(0, 1, 8'h20, 0, 0);
    check("R7 any trap halt", {31'd0, dbg_active}, 1);
    rd_cause("R7 any cause", 4);
    resume("R10 resume");
    set_ctrl(32'h4);
    bus_acc(1, A_MASK, 32'h0000_0020);
    bus_acc(0, A_MASK, 0); check("R14 mask readback", r_data, 32'h20);
    fire(0, 1, 8'h06, 0, 0);
    check("R7 masked-off trap", {31'd0, dbg_active}, 0);
    fire(0, 1, 8'h25, 0, 0);
    check("R7 out of range trap", {31'd0, dbg_active}, 0);
    fire(0, 1, 8'h05, 0, 0);
    check("R7 selected trap halt", {31'd0, dbg_active}, 1);
    rd_cause("R7 sel cause", 4);
    resume("R10 resume");
    set_ctrl(0);
  endtask

  task automatic t_step;
    fire(0, 0, 0, 0, 1);
    check("R8 step disabled", {31'd0, dbg_active}, 0);
    set_ctrl(32'h8);
    bus_acc(0, A_CTRL, 0); check("R14 ctrl cfg readback", r_data, 32'h8);
    fire(0, 0, 0, 0, 1);
    check("R8 step halt", {31'd0, dbg_active}, 1);
    rd_cause("R8 cause", 5);
    resume("R10 resume");
  endtask

  task automatic t_prio;
    fire(1, 0, 0, 0, 1);
    rd_cause("R9 sw over step", 3);
    resume("R10 resume");
    fire(1, 1, 8'h0B, 1, 1);
    rd_cause("R9 err wins", 1);
    resume("R10 resume");
    fire(1, 1, 8'h0B, 0, 0);
    rd_cause("R9 hw over sw", 2);
    resume("R10 resume");
    set_ctrl(0);
  endtask

  task automatic t_regions;
    bus_acc(1, A_CORE, 32'h55);
    check("R11 running core err", {29'd0, r_ack, r_err, r_core}, 32'h6);
    bus_acc(1, A_CTRL, 32'h10);
    bus_acc(0, A_CORE, 0);
    check("R11 halted core ok", {29'd0, r_ack, r_err, r_core}, 32'h5);
    resume("R10 resume");
    set_ctrl(32'h1);
    trc_done = 0;
    bus_acc(0, A_TRC, 0);
    check("R12 tracing refused", {29'd0, r_ack, r_err, r_trc}, 32'h6);
    trc_done = 1;
    bus_acc(0, A_TRC, 0);
    check("R12 trace done ok", {29'd0, r_ack, r_err, r_trc}, 32'h5);
    trc_done = 0;
    set_ctrl(0);
    bus_acc(0, A_TRC, 0);
    check("R12 trace off ok", {29'd0, r_ack, r_err, r_trc}, 32'h5);
    bus_acc(0, A_NONE, 0);
    check("R13 unmapped err", {30'd0, r_ack, r_err}, 32'h3);
    bus_acc(1, A_OUT, 32'h10);
    check("R13 outside no ack", {30'd0, r_ack, dbg_active}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ev_swbrk = 0; ev_trap_vld = 0; ev_trap_type = 0; ev_err_trap = 0;
    ev_step_done = 0; brk_pin = 0; trc_done = 0; bus_sel = 0; bus_we = 0;
    bus_addr = 0; bus_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_swbrk;
    t_hwtrap;
    t_errtrap;
    t_ext;
    t_brknow;
    t_filter;
    t_step;
    t_prio;
    t_regions;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule